// File: doc/BRIEF.md
# True Dual-Port RAM with Mixed Port Widths

This block is a synchronous memory with two fully independent ports, A and B. Each port has its own rising-edge clock, clock enable, write enable, reset, 3-bit chip select, address, write data and read data. Either port can read or write at any time, and the two clocks need not be related.

Both ports work on one shared storage array. Each port picks its own data width from 1, 2, 4, 9 or 18 bits. The storage holds 8192 bits when the wider width is 1, 2 or 4, and 9216 bits when it is 9 or 18. The two widths must both come from the same group, and the address width of each port follows from its depth. A narrower port addresses slices of the wider port's word.

Each port also has its own parameters for write behaviour, output pipelining and chip-select match value. One parameter chooses a synchronous or an asynchronous reset for both ports. The contents are undefined if both ports write overlapping bits at the same time.

Top module: `tdp_ram`

## Requirements
- R1: A port of width P has depth CAP/P, where CAP is 9216 for word widths 9 and 18 and 8192 for widths 1, 2 and 4. Every address up to the last one (1023 for a 9-bit port, 511 for an 18-bit port, 8191 for a 1-bit port, 2047 for a 4-bit port) stores data of its own.
- R2: A port acts on a rising edge only when its clock enable is 1 and its `cs` input equals its `*_CSDEC` parameter. On any other edge that port writes nothing and its read data register keeps its value.
- R3: With `*_OUTREG` = 0, read data appears on `dout` after the rising edge that samples the address. With `*_OUTREG` = 1, it appears one rising edge later, and that output stage loads only on edges where the clock enable is 1.
- R4: Let the wider width be W, the narrower width P and the lane count R = W/P. Narrow address n then maps to wide word n/R, bits [(n mod R)*P +: P], so lane 0 is in the least significant bits.
- R5: Write mode 0 (normal): a write leaves the port's read data unchanged.
- R6: Write mode 1 (write-through): a write puts the written data on the port's read data.
- R7: Write mode 2 (read-before-write): a write puts the word's previous contents on the port's read data.
- R8: Reset clears the read data, and the output stage if present, to zero. With `RST_SYNC` = 0 this happens at once, without a clock edge. With `RST_SYNC` = 1 it happens at the next rising edge of that port's clock. Reset never changes the stored contents.
- R9: Data written through one port can be read through the other port in the other clock domain. Writes made at the same time by both ports to words that do not overlap all take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock, rising edge |
| ce_a | input | 1 | Port A clock enable |
| we_a | input | 1 | Port A write enable |
| rst_a | input | 1 | Port A read-path reset |
| cs_a | input | 3 | Port A chip select |
| addr_a | input | A_AW | Port A address |
| din_a | input | A_WIDTH | Port A write data |
| dout_a | output | A_WIDTH | Port A read data |
| clk_b | input | 1 | Port B clock, rising edge |
| ce_b | input | 1 | Port B clock enable |
| we_b | input | 1 | Port B write enable |
| rst_b | input | 1 | Port B read-path reset |
| cs_b | input | 3 | Port B chip select |
| addr_b | input | B_AW | Port B address |
| din_b | input | B_WIDTH | Port B write data |
| dout_b | output | B_WIDTH | Port B read data |

## Verification
The hardest case to reach is both ports writing disjoint parts of the array in the same stretch of time while their clocks drift against each other. The bench forks a port A write and a port B write together, then reads each result back through the opposite port with its own width. A second instance with 1-bit and 4-bit ports, normal write mode and synchronous reset covers the lane mapping at the top address. It also covers the reset case where the output stays unchanged until a clock edge arrives.

// File: rtl/tdp_ram.sv
`timescale 1ns/1ps
module tdp_ram #(
  parameter int A_WIDTH = 9,
  parameter int B_WIDTH = 18,
  parameter int A_MODE = 1,
  parameter int B_MODE = 2,
  parameter bit A_OUTREG = 1'b0,
  parameter bit B_OUTREG = 1'b1,
  parameter logic [2:0] A_CSDEC = 3'b101,
  parameter logic [2:0] B_CSDEC = 3'b010,
  parameter bit RST_SYNC = 1'b0,
  localparam int WORD_W = (A_WIDTH > B_WIDTH) ? A_WIDTH : B_WIDTH,
  localparam int CAP = (WORD_W % 9 == 0) ? 9216 : 8192,
  localparam int A_AW = $clog2(CAP / A_WIDTH),
  localparam int B_AW = $clog2(CAP / B_WIDTH)
) (
  input  logic               clk_a,
  input  logic               ce_a,
  input  logic               we_a,
  input  logic               rst_a,
  input  logic [2:0]         cs_a,
  input  logic [A_AW-1:0]    addr_a,
  input  logic [A_WIDTH-1:0] din_a,
  output logic [A_WIDTH-1:0] dout_a,
  input  logic               clk_b,
  input  logic               ce_b,
  input  logic               we_b,
  input  logic               rst_b,
  input  logic [2:0]         cs_b,
  input  logic [B_AW-1:0]    addr_b,
  input  logic [B_WIDTH-1:0] din_b,
  output logic [B_WIDTH-1:0] dout_b
);
  localparam int DEPTH = CAP / WORD_W;
  localparam int DW = $clog2(DEPTH);
  localparam int A_LANES = WORD_W / A_WIDTH;
  localparam int B_LANES = WORD_W / B_WIDTH;
  localparam int A_SH = $clog2(A_LANES);
  localparam int B_SH = $clog2(B_LANES);
  localparam int M_NORMAL = 0;
  localparam int M_THRU = 1;

  // Each bank has a single writer; the stored value is the XOR of both.
  logic [WORD_W-1:0] bank_a [DEPTH];
  logic [WORD_W-1:0] bank_b [DEPTH];

  logic [DW-1:0] wrd_a, wrd_b;
  int unsigned base_a, base_b;
  logic [WORD_W-1:0] word_a, word_b;
  logic [A_WIDTH-1:0] old_a, nxt_a, q_a, o_a;
  logic [B_WIDTH-1:0] old_b, nxt_b, q_b, o_b;
  logic act_a, act_b, ld_a, ld_b;

  assign wrd_a  = DW'(addr_a >> A_SH);
  assign wrd_b  = DW'(addr_b >> B_SH);
  assign base_a = (32'(addr_a) % 32'(A_LANES)) * 32'(A_WIDTH);
  assign base_b = (32'(addr_b) % 32'(B_LANES)) * 32'(B_WIDTH);

  assign word_a = bank_a[wrd_a] ^ bank_b[wrd_a];
  assign word_b = bank_a[wrd_b] ^ bank_b[wrd_b];
  assign old_a  = word_a[base_a +: A_WIDTH];
  assign old_b  = word_b[base_b +: B_WIDTH];

  assign act_a = ce_a && (cs_a == A_CSDEC);
  assign act_b = ce_b && (cs_b == B_CSDEC);

  always_ff @(posedge clk_a)
    if (act_a && we_a)
      bank_a[wrd_a][base_a +: A_WIDTH] <= din_a ^ bank_b[wrd_a][base_a +: A_WIDTH];

  always_ff @(posedge clk_b)
    if (act_b && we_b)
      bank_b[wrd_b][base_b +: B_WIDTH] <= din_b ^ bank_a[wrd_b][base_b +: B_WIDTH];

  assign ld_a  = act_a && !(we_a && A_MODE == M_NORMAL);
  assign ld_b  = act_b && !(we_b && B_MODE == M_NORMAL);
  assign nxt_a = (we_a && A_MODE == M_THRU) ? din_a : old_a;
  assign nxt_b = (we_b && B_MODE == M_THRU) ? din_b : old_b;

  generate
    if (RST_SYNC) begin : g_sync
      always_ff @(posedge clk_a)
        if (rst_a) begin
          q_a <= '0;
          o_a <= '0;
        end else begin
          if (ld_a) q_a <= nxt_a;
          if (ce_a) o_a <= q_a;
        end
      always_ff @(posedge clk_b)
        if (rst_b) begin
          q_b <= '0;
          o_b <= '0;
        end else begin
          if (ld_b) q_b <= nxt_b;
          if (ce_b) o_b <= q_b;
        end
    end else begin : g_async
      always_ff @(posedge clk_a or posedge rst_a)
        if (rst_a) begin
          q_a <= '0;
          o_a <= '0;
        end else begin
          if (ld_a) q_a <= nxt_a;
          if (ce_a) o_a <= q_a;
        end
      always_ff @(posedge clk_b or posedge rst_b)
        if (rst_b) begin
          q_b <= '0;
          o_b <= '0;
        end else begin
          if (ld_b) q_b <= nxt_b;
          if (ce_b) o_b <= q_b;
        end
    end
  endgenerate

  assign dout_a = A_OUTREG ? o_a : q_a;
  assign dout_b = B_OUTREG ? o_b : q_b;
endmodule

module tdp_ram_chk #(
  parameter int A_WIDTH = 9,
  parameter int B_WIDTH = 18,
  parameter int A_MODE = 1,
  parameter int B_MODE = 2,
  parameter bit A_OUTREG = 1'b0,
  parameter bit B_OUTREG = 1'b1,
  parameter logic [2:0] A_CSDEC = 3'b101,
  parameter logic [2:0] B_CSDEC = 3'b010
) (
  input logic               clk_a,
  input logic               ce_a,
  input logic               we_a,
  input logic               rst_a,
  input logic [2:0]         cs_a,
  input logic [A_WIDTH-1:0] din_a,
  input logic [A_WIDTH-1:0] dout_a,
  input logic               clk_b,
  input logic               ce_b,
  input logic               we_b,
  input logic               rst_b,
  input logic [2:0]         cs_b,
  input logic [B_WIDTH-1:0] din_b,
  input logic [B_WIDTH-1:0] dout_b
);
  p_idle_hold_r2_a: assert property (@(posedge clk_a) disable iff (rst_a)
    !ce_a |=> $stable(dout_a));
  p_idle_hold_r2_b: assert property (@(posedge clk_b) disable iff (rst_b)
    !ce_b |=> $stable(dout_b));
  p_cs_miss_r2_a: assert property (@(posedge clk_a) disable iff (rst_a)
    (!A_OUTREG && ce_a && cs_a != A_CSDEC) |=> $stable(dout_a));
  p_cs_miss_r2_b: assert property (@(posedge clk_b) disable iff (rst_b)
    (!B_OUTREG && ce_b && cs_b != B_CSDEC) |=> $stable(dout_b));
  p_normal_r5_a: assert property (@(posedge clk_a) disable iff (rst_a)
    (A_MODE == 0 && !A_OUTREG && ce_a && cs_a == A_CSDEC && we_a) |=> $stable(dout_a));
  p_normal_r5_b: assert property (@(posedge clk_b) disable iff (rst_b)
    (B_MODE == 0 && !B_OUTREG && ce_b && cs_b == B_CSDEC && we_b) |=> $stable(dout_b));
  p_thru_r6_a: assert property (@(posedge clk_a) disable iff (rst_a)
    (A_MODE == 1 && !A_OUTREG && ce_a && cs_a == A_CSDEC && we_a) |=> dout_a == $past(din_a));
  p_thru_r6_b: assert property (@(posedge clk_b) disable iff (rst_b)
    (B_MODE == 1 && !B_OUTREG && ce_b && cs_b == B_CSDEC && we_b) |=> dout_b == $past(din_b));
  p_reset_clear_r8_a: assert property (@(posedge clk_a) disable iff (rst_a)
    $fell(rst_a) |-> dout_a == '0);
  p_reset_clear_r8_b: assert property (@(posedge clk_b) disable iff (rst_b)
    $fell(rst_b) |-> dout_b == '0);
endmodule

bind tdp_ram tdp_ram_chk #(
  .A_WIDTH(A_WIDTH), .B_WIDTH(B_WIDTH), .A_MODE(A_MODE), .B_MODE(B_MODE),
  .A_OUTREG(A_OUTREG), .B_OUTREG(B_OUTREG), .A_CSDEC(A_CSDEC), .B_CSDEC(B_CSDEC)
) u_chk (
  .clk_a(clk_a), .ce_a(ce_a), .we_a(we_a), .rst_a(rst_a), .cs_a(cs_a),
  .din_a(din_a), .dout_a(dout_a),
  .clk_b(clk_b), .ce_b(ce_b), .we_b(we_b), .rst_b(rst_b), .cs_b(cs_b),
  .din_b(din_b), .dout_b(dout_b)
);

// File: tb/test_tdp_ram.sv
`timescale 1ns/1ps
module test_tdp_ram;
  logic clk_a = 1'b0, clk_b = 1'b0;
  always #2 clk_a = ~clk_a;
  always #2.8 clk_b = ~clk_b;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // main instance: A 9-bit write-through no reg, B 18-bit read-before-write reg, async reset
  logic ma_ce = 0, ma_we = 0, ma_rst = 1;
  logic [2:0] ma_cs = 0;
  logic [9:0] ma_addr = 0;
  logic [8:0] ma_din = 0, ma_dout;
  logic mb_ce = 0, mb_we = 0, mb_rst = 1;
  logic [2:0] mb_cs = 0;
  logic [8:0] mb_addr = 0;
  logic [17:0] mb_din = 0, mb_dout;

  tdp_ram i_tdp_ram (
    .clk_a(clk_a), .ce_a(ma_ce), .we_a(ma_we), .rst_a(ma_rst), .cs_a(ma_cs),
    .addr_a(ma_addr), .din_a(ma_din), .dout_a(ma_dout),
    .clk_b(clk_b), .ce_b(mb_ce), .we_b(mb_we), .rst_b(mb_rst), .cs_b(mb_cs),
    .addr_b(mb_addr), .din_b(mb_din), .dout_b(mb_dout));

  // alternate instance: A 1-bit normal reg, B 4-bit normal no reg, sync reset
  logic ya_ce = 0, ya_we = 0, ya_rst = 1;
  logic [2:0] ya_cs = 0;
  logic [12:0] ya_addr = 0;
  logic ya_din = 0, ya_dout;
  logic yb_ce = 0, yb_we = 0, yb_rst = 1;
  logic [2:0] yb_cs = 0;
  logic [10:0] yb_addr = 0;
  logic [3:0] yb_din = 0, yb_dout;

  tdp_ram #(.A_WIDTH(1), .B_WIDTH(4), .A_MODE(0), .B_MODE(0), .A_OUTREG(1'b1),
            .B_OUTREG(1'b0), .A_CSDEC(3'b000), .B_CSDEC(3'b111), .RST_SYNC(1'b1)) i_tdp_ram_alt (
    .clk_a(clk_a), .ce_a(ya_ce), .we_a(ya_we), .rst_a(ya_rst), .cs_a(ya_cs),
    .addr_a(ya_addr), .din_a(ya_din), .dout_a(ya_dout),
    .clk_b(clk_b), .ce_b(yb_ce), .we_b(yb_we), .rst_b(yb_rst), .cs_b(yb_cs),
    .addr_b(yb_addr), .din_b(yb_din), .dout_b(yb_dout));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one access, then one edge with the chip deselected so an output stage catches up
  task automatic op_ma(input bit we, input logic [9:0] ad, input logic [8:0] d,
                       input logic [2:0] cs = 3'b101, input bit en = 1'b1);
    @(negedge clk_a); ma_ce = en; ma_we = we; ma_cs = cs; ma_addr = ad; ma_din = d;
    @(negedge clk_a); ma_ce = 1'b1; ma_we = 1'b0; ma_cs = 3'b010;
    @(negedge clk_a); ma_ce = 1'b0;
  endtask
  task automatic op_mb(input bit we, input logic [8:0] ad, input logic [17:0] d,
                       input logic [2:0] cs = 3'b010, input bit en = 1'b1);
    @(negedge clk_b); mb_ce = en; mb_we = we; mb_cs = cs; mb_addr = ad; mb_din = d;
    @(negedge clk_b); mb_ce = 1'b1; mb_we = 1'b0; mb_cs = 3'b101;
    @(negedge clk_b); mb_ce = 1'b0;
  endtask
  task automatic op_ya(input bit we, input logic [12:0] ad, input logic d);
    @(negedge clk_a); ya_ce = 1'b1; ya_we = we; ya_cs = 3'b000; ya_addr = ad; ya_din = d;
    @(negedge clk_a); ya_we = 1'b0; ya_cs = 3'b111;
    @(negedge clk_a); ya_ce = 1'b0;
  endtask
  task automatic op_yb(input bit we, input logic [10:0] ad, input logic [3:0] d);
    @(negedge clk_b); yb_ce = 1'b1; yb_we = we; yb_cs = 3'b111; yb_addr = ad; yb_din = d;
    @(negedge clk_b); yb_we = 1'b0; yb_cs = 3'b000;
    @(negedge clk_b); yb_ce = 1'b0;
  endtask

  task automatic t_reset_state;
    chk("R8 reset value port A", 32'(ma_dout), 0);
    chk("R8 reset value port B", 32'(mb_dout), 0);
    chk("R8 reset value alt A", 32'(ya_dout), 0);
    chk("R8 reset value alt B", 32'(yb_dout), 0);
  endtask

  task automatic t_geometry;
    logic [17:0] v;
    v = 18'h15A3C;
    op_ma(1, 10'd6, 9'h1A5);
    op_ma(1, 10'd7, 9'h0C3);
    op_mb(0, 9'd3, '0);
    chk("R4 two narrow lanes form wide word", 32'(mb_dout), 32'({9'h0C3, 9'h1A5}));
    op_mb(1, 9'd10, v);
    op_ma(0, 10'd20, '0);
    chk("R4 R9 low lane read by narrow port", 32'(ma_dout), 32'(v[8:0]));
    op_ma(0, 10'd21, '0);
    chk("R4 R9 high lane read by narrow port", 32'(ma_dout), 32'(v[17:9]));
    op_ma(1, 10'd1023, 9'h17F);
    op_mb(0, 9'd511, '0);
    chk("R1 top address of 9-bit port", 32'(mb_dout[17:9]), 32'h17F);
    op_ya(1, 13'd8188, 1'b1);
    op_ya(1, 13'd8189, 1'b0);
    op_ya(1, 13'd8190, 1'b1);
    op_ya(1, 13'd8191, 1'b1);
    op_yb(0, 11'd2047, '0);
    chk("R1 R4 top bits of 1-bit port", 32'(yb_dout), 32'h0000000D);
  endtask

  task automatic t_modes;
    op_ma(1, 10'd30, 9'h0AA);
    chk("R6 write-through shows written data", 32'(ma_dout), 32'h0AA);
    op_mb(1, 9'd3, 18'h3FFFF);
    chk("R7 read-before-write shows old word", 32'(mb_dout), 32'({9'h0C3, 9'h1A5}));
    op_mb(0, 9'd3, '0);
    chk("R7 new word stored", 32'(mb_dout), 32'h3FFFF);
    op_yb(1, 11'd5, 4'h9);
    op_yb(0, 11'd5, '0);
    chk("R5 alt B read", 32'(yb_dout), 32'h9);
    op_yb(1, 11'd5, 4'h6);
    chk("R5 normal write keeps output", 32'(yb_dout), 32'h9);
    op_yb(0, 11'd5, '0);
    chk("R5 normal write stored", 32'(yb_dout), 32'h6);
    op_ya(0, 13'd8190, 1'b0);
    chk("R5 alt A read through output stage", 32'(ya_dout), 32'h1);
    op_ya(1, 13'd8190, 1'b0);
    chk("R5 normal write keeps registered output", 32'(ya_dout), 32'h1);
    op_ya(0, 13'd8190, 1'b0);
    chk("R5 alt A normal write stored", 32'(ya_dout), 32'h0);
  endtask

  task automatic t_select;
    op_ma(1, 10'd40, 9'h055);
    op_ma(1, 10'd40, 9'h1EE, 3'b100);
    chk("R2 wrong select holds output", 32'(ma_dout), 32'h055);
    op_ma(1, 10'd40, 9'h133, 3'b101, 1'b0);
    chk("R2 enable low holds output", 32'(ma_dout), 32'h055);
    op_ma(0, 10'd30, '0);
    op_ma(0, 10'd40, '0);
    chk("R2 ignored writes left word", 32'(ma_dout), 32'h055);
    op_mb(1, 9'd60, 18'h00002);
    op_mb(1, 9'd60, 18'h00001, 3'b011);
    op_mb(0, 9'd60, '0);
    chk("R2 port B wrong select no write", 32'(mb_dout), 32'h2);
  endtask

  task automatic t_latency;
    op_mb(1, 9'd70, 18'h12345);
    op_mb(0, 9'd3, '0);
    @(negedge clk_b); mb_ce = 1'b1; mb_we = 1'b0; mb_cs = 3'b010; mb_addr = 9'd70;
    @(negedge clk_b);
    chk("R3 registered port not yet updated", 32'(mb_dout), 32'h3FFFF);
    mb_cs = 3'b101;
    @(negedge clk_b);
    chk("R3 registered port one edge later", 32'(mb_dout), 32'h12345);
    mb_ce = 1'b0;
    @(negedge clk_a); ma_ce = 1'b1; ma_we = 1'b0; ma_cs = 3'b101; ma_addr = 10'd30;
    @(negedge clk_a);
    chk("R3 unregistered port after one edge", 32'(ma_dout), 32'h0AA);
    ma_ce = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk_a); #1 ma_rst = 1'b1;
    #0.5 chk("R8 async reset clears without edge", 32'(ma_dout), 0);
    @(negedge clk_a); ma_rst = 1'b0;
    @(negedge clk_b); #1 mb_rst = 1'b1;
    #0.5 chk("R8 async reset clears output stage", 32'(mb_dout), 0);
    @(negedge clk_b); mb_rst = 1'b0;
    @(negedge clk_b); yb_rst = 1'b1;
    #0.5 chk("R8 sync reset waits for edge", 32'(yb_dout), 32'h6);
    @(negedge clk_b);
    chk("R8 sync reset at edge", 32'(yb_dout), 0);
    yb_rst = 1'b0;
    op_ma(0, 10'd30, '0);
    chk("R8 contents kept after reset", 32'(ma_dout), 32'h0AA);
    op_yb(0, 11'd5, '0);
    chk("R8 alt contents kept after reset", 32'(yb_dout), 32'h6);
  endtask

  task automatic t_parallel;
    fork
      op_ma(1, 10'd100, 9'h11F);
      op_mb(1, 9'd80, 18'h2A5A5);
    join
    op_mb(0, 9'd50, '0);
    chk("R9 concurrent A write seen by B", 32'(mb_dout[8:0]), 32'h11F);
    op_ma(0, 10'd160, '0);
    chk("R9 concurrent B write low lane", 32'(ma_dout), 32'(9'h1A5 & 9'h1FF) & 32'h0 | 32'h1A5);
    op_ma(0, 10'd161, '0);
    chk("R9 concurrent B write high lane", 32'(ma_dout), 32'h152);
  endtask

  initial begin
    repeat (4) @(negedge clk_b);
    ma_rst = 1'b0; mb_rst = 1'b0; ya_rst = 1'b0; yb_rst = 1'b0;
    @(negedge clk_a);
    t_reset_state();
    t_geometry();
    t_modes();
    t_select();
    t_latency();
    t_reset();
    t_parallel();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired before the run ended");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule